// File: doc/BRIEF.md
# Three-Port Parallel I/O Peripheral

This block is a general-purpose parallel I/O peripheral on a synchronous 8-bit register bus. It has three 8-bit ports and a write-only control register, all selected by a 2-bit address. Only plain static input/output is supported. A control word sets the direction of each whole port. The third port is split into an upper and a lower nibble, and each nibble is configured on its own.

Software changes single pins by reading a port, changing bits and writing the port back. For this to work, a read of an output port returns the value held in its output register, not the pin level. A read of an input port returns the pins after a two-flop synchronizer. The pin side exposes three vectors: output values, output enables and input samples. Port A occupies bits 7..0 of each vector, port B bits 15..8 and port C bits 23..16.

Top module: `tri_port_pio`

## Requirements
- R1: A synchronous active-low reset makes every port an input, deasserts all of `pad_oe` and clears every output latch, so `pad_out` reads 0.
- R2: Address 0 selects port A, address 1 selects port B and address 2 selects port C. A write to a port with `cs` and `wr` high stores `wdata` in that port's latch. Reading an output-configured port returns that latch, with bit n being pin n of the port.
- R3: Address 3 is the control register. When a write there has bit 7 set, directions are loaded as follows: bit 4 sets port A, bit 1 sets port B, bit 3 sets port C bits 7..4 and bit 0 sets port C bits 3..0. A 1 makes the group an input (output enables low) and a 0 makes it an output. The new `pad_oe` is visible the cycle after the write.
- R4: A control write with bit 7 clear changes neither the directions nor any latch.
- R5: A control write with bit 7 set clears all three output latches.
- R6: Reading an input-configured port returns `pad_in` through two flops. A read strobe in the cycle right after a pin change still returns the old level. The new level is returned once the pins have been stable for two edges before the read edge.
- R7: On a port C read, each nibble returns its latch or its synchronized pins according to its own direction.
- R8: A write to an input-configured port updates its latch, and `pad_out` shows the new value, but the output enables stay low.
- R9: Reading address 3 returns 0x00.
- R10: `rdata` is registered. It holds the read value the cycle after a read strobe and 0 after any cycle without one. When `rd` and `wr` hit the same port in one cycle, the read returns the contents from before the write.
- R11: With `cs` low, `rd` and `wr` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register address (0 A, 1 B, 2 C, 3 control) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pad_in | input | 24 | Pin input levels, A in 7..0, B in 15..8, C in 23..16 |
| pad_out | output | 24 | Pin output values, same layout |
| pad_oe | output | 24 | Pin output enables, active high, same layout |

## Verification
Two functions can act in the same cycle: a read and a write to the same port, and a pin change together with a read strobe. The first is provoked by raising `rd` and `wr` together on port B. It passes if the read returns the old latch and a following read returns the new one. The second is provoked by changing `pad_in` in the same cycle as a read strobe. It passes if the old level comes back, and if the new level comes back once two edges have passed.

// File: rtl/ppi_pkg.sv
// Package: shared constants and types for the three-port parallel I/O block.
// Assumes an 8-bit bus and byte-wide ports; the control bit positions below
// are fixed because software encodes them.
package ppi_pkg;
    localparam int BUS_W    = 8;
    localparam int NPORTS   = 3;
    localparam int ADDR_W   = 2;

    localparam int CW_MODE  = 7;
    localparam int CW_A     = 4;
    localparam int CW_CHI   = 3;
    localparam int CW_B     = 1;
    localparam int CW_CLO   = 0;

    localparam logic [ADDR_W-1:0] SEL_A    = 2'd0;
    localparam logic [ADDR_W-1:0] SEL_B    = 2'd1;
    localparam logic [ADDR_W-1:0] SEL_C    = 2'd2;
    localparam logic [ADDR_W-1:0] SEL_CTRL = 2'd3;

    // Direction of each configurable group, 1 = input
    typedef struct packed {
        logic a_in;
        logic b_in;
        logic chi_in;
        logic clo_in;
    } dir_t;

    localparam dir_t DIR_RESET = '{a_in: 1'b1, b_in: 1'b1, chi_in: 1'b1, clo_in: 1'b1};
endpackage

// File: rtl/ppi_ctrl.sv
// Module: control register decoder.
// Holds the direction state and emits a one-cycle clear pulse for the output
// latches on every accepted mode-set write. Assumes the write strobe is
// already qualified by chip select.
module ppi_ctrl
    import ppi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [BUS_W-1:0] wdata,
    output dir_t             dir,
    output logic             latch_clr
);
    logic accept;

    // Purpose: accept only control words carrying the mode-set flag
    always_comb begin
        accept = ctrl_we && wdata[CW_MODE];
    end

    // Purpose: register the port directions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir <= DIR_RESET;
        end else if (accept) begin
            dir.a_in   <= wdata[CW_A];
            dir.b_in   <= wdata[CW_B];
            dir.chi_in <= wdata[CW_CHI];
            dir.clo_in <= wdata[CW_CLO];
        end
    end

    // Purpose: combinational clear request, applied by the port latches
    always_comb begin
        latch_clr = accept;
    end
endmodule

// File: rtl/ppi_port.sv
// Module: one parallel port.
// Output latch, two-flop input synchronizer and per-half read selection.
// Assumes W is even; each half of the port has its own direction input, and
// whole ports tie both direction inputs together.
module ppi_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         clr,
    input  logic [W-1:0] wdata,
    input  logic         dir_hi,
    input  logic         dir_lo,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] oe,
    output logic [W-1:0] rd_val
);
    localparam int HALF = W / 2;

    logic [W-1:0] sync1_q;
    logic [W-1:0] sync2_q;

    // Purpose: output latch, cleared on mode-set, loaded on data write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (clr) begin
            latch_q <= '0;
        end else if (wr_en) begin
            latch_q <= wdata;
        end
    end

    // Purpose: two-stage synchronizer for the pin inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= pin_in;
            sync2_q <= sync1_q;
        end
    end

    genvar h;
    generate
        for (h = 0; h < 2; h++) begin : g_half
            logic dir_h;
            // Purpose: choose this half's direction bit
            always_comb begin
                dir_h = (h == 1) ? dir_hi : dir_lo;
            end
            // Purpose: drive enables and select the read source for this half
            always_comb begin
                oe[h*HALF +: HALF]     = {HALF{~dir_h}};
                rd_val[h*HALF +: HALF] = dir_h ? sync2_q[h*HALF +: HALF]
                                               : latch_q[h*HALF +: HALF];
            end
        end
    endgenerate
endmodule

// File: rtl/tri_port_pio.sv
// Module: top of the three-port parallel I/O peripheral.
// Decodes the bus, instantiates the control register and three ports, and
// registers read data. Assumes strobes are synchronous to clk and that a read
// and a write in the same cycle see the pre-write state.
module tri_port_pio
    import ppi_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs,
    input  logic                    rd,
    input  logic                    wr,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BUS_W-1:0]        wdata,
    output logic [BUS_W-1:0]        rdata,
    input  logic [NPORTS*BUS_W-1:0] pad_in,
    output logic [NPORTS*BUS_W-1:0] pad_out,
    output logic [NPORTS*BUS_W-1:0] pad_oe
);
    dir_t             dir;
    logic             latch_clr;
    logic             bus_wr;
    logic             bus_rd;
    logic [BUS_W-1:0] port_rd [NPORTS];
    logic [BUS_W-1:0] rd_mux;
    logic [NPORTS-1:0] dir_hi_v;
    logic [NPORTS-1:0] dir_lo_v;

    // Purpose: qualify strobes with chip select
    always_comb begin
        bus_wr = cs && wr;
        bus_rd = cs && rd;
    end

    ppi_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (bus_wr && (addr == SEL_CTRL)),
        .wdata     (wdata),
        .dir       (dir),
        .latch_clr (latch_clr)
    );

    // Purpose: map group directions onto each port's two halves
    always_comb begin
        dir_hi_v = {dir.chi_in, dir.b_in, dir.a_in};
        dir_lo_v = {dir.clo_in, dir.b_in, dir.a_in};
    end

    genvar p;
    generate
        for (p = 0; p < NPORTS; p++) begin : g_port
            ppi_port #(.W(BUS_W)) u_port (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (bus_wr && (addr == ADDR_W'(p))),
                .clr     (latch_clr),
                .wdata   (wdata),
                .dir_hi  (dir_hi_v[p]),
                .dir_lo  (dir_lo_v[p]),
                .pin_in  (pad_in[p*BUS_W +: BUS_W]),
                .latch_q (pad_out[p*BUS_W +: BUS_W]),
                .oe      (pad_oe[p*BUS_W +: BUS_W]),
                .rd_val  (port_rd[p])
            );
        end
    endgenerate

    // Purpose: select the read source by address; control reads as zero
    always_comb begin
        case (addr)
            SEL_A:   rd_mux = port_rd[0];
            SEL_B:   rd_mux = port_rd[1];
            SEL_C:   rd_mux = port_rd[2];
            default: rd_mux = '0;
        endcase
    end

    // Purpose: register read data, zero when no read is strobed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (bus_rd) begin
            rdata <= rd_mux;
        end else begin
            rdata <= '0;
        end
    end
endmodule

// File: rtl/tri_port_pio_chk.sv
// Module: assertion checker bound to tri_port_pio.
module tri_port_pio_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cs,
    input logic        rd,
    input logic        wr,
    input logic [1:0]  addr,
    input logic [7:0]  wdata,
    input logic [7:0]  rdata,
    input logic [23:0] pad_out,
    input logic [23:0] pad_oe
);
    logic seen_rst;

    // Purpose: mark that one reset edge has been seen
    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst === 1'b1 && $past(!rst_n)) |-> (pad_oe == '0 && pad_out == '0));

    p_dir_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && addr == 2'd3 && wdata[7]) |=>
        (pad_oe[7:0] == {8{~$past(wdata[4])}} && pad_oe[15:8] == {8{~$past(wdata[1])}} &&
         pad_oe[23:20] == {4{~$past(wdata[3])}} && pad_oe[19:16] == {4{~$past(wdata[0])}}));

    p_ignored_ctrl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && addr == 2'd3 && !wdata[7]) |=> ($stable(pad_oe) && $stable(pad_out)));

    p_modeset_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && addr == 2'd3 && wdata[7]) |=> (pad_out == '0));

    p_ctrl_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && addr == 2'd3) |=> (rdata == 8'h00));

    p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd) |=> (rdata == 8'h00));

    p_cs_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs) |=> ($stable(pad_oe) && $stable(pad_out)));
endmodule

bind tri_port_pio tri_port_pio_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (cs),
    .rd      (rd),
    .wr      (wr),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
);

// File: tb/tri_port_pio_tb.sv
module tri_port_pio_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [23:0] pad_in = '0;
    logic [23:0] pad_out, pad_oe;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tri_port_pio u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input logic [23:0] got, input logic [23:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [23:0] exp_oe(input logic [7:0] cw);
        return {{4{~cw[3]}}, {4{~cw[0]}}, {8{~cw[1]}}, {8{~cw[4]}}};
    endfunction

    task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk); cs = 0; wr = 0;
    endtask

    task automatic do_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); cs = 1; rd = 1; addr = a;
        @(negedge clk); d = rdata; cs = 0; rd = 0;
    endtask

    task automatic t_reset;
        chk("R1 oe", pad_oe, 24'h0);
        chk("R1 out", pad_out, 24'h0);
        chk("R10 idle rdata", {16'h0, rdata}, 24'h0);
    endtask

    task automatic t_outputs_rw;
        logic [7:0] d;
        do_wr(2'd3, 8'h80);
        chk("R3 all out", pad_oe, 24'hFFFFFF);
        do_wr(2'd0, 8'h5A); do_wr(2'd1, 8'hC3); do_wr(2'd2, 8'h96);
        chk("R2 pad_out", pad_out, 24'h96C35A);
        do_rd(2'd0, d); chk("R2 read A", {16'h0, d}, 24'h5A);
        do_rd(2'd1, d); chk("R2 read B", {16'h0, d}, 24'hC3);
        do_rd(2'd2, d); chk("R2 read C", {16'h0, d}, 24'h96);
    endtask

    task automatic t_dir_bits;
        logic [7:0] cws [4] = '{8'h90, 8'h82, 8'h88, 8'h81};
        for (int i = 0; i < 4; i++) begin
            do_wr(2'd3, cws[i]);
            chk("R3 oe decode", pad_oe, exp_oe(cws[i]));
        end
    endtask

    task automatic t_ignored_ctrl;
        logic [7:0] d;
        do_wr(2'd3, 8'h80);
        do_wr(2'd0, 8'h11);
        do_wr(2'd3, 8'h1B);
        chk("R4 oe kept", pad_oe, 24'hFFFFFF);
        chk("R4 out kept", pad_out, 24'h000011);
        do_rd(2'd0, d); chk("R4 read A", {16'h0, d}, 24'h11);
    endtask

    task automatic t_modeset_clear;
        logic [7:0] d;
        do_wr(2'd1, 8'h77); do_wr(2'd2, 8'hEE);
        do_wr(2'd3, 8'h80);
        chk("R5 cleared", pad_out, 24'h0);
        do_rd(2'd1, d); chk("R5 read B", {16'h0, d}, 24'h0);
    endtask

    task automatic t_input_sync;
        logic [7:0] d;
        do_wr(2'd3, 8'h9B);
        chk("R3 all in", pad_oe, 24'h0);
        @(negedge clk); pad_in = 24'hA53C77;
        @(negedge clk); @(negedge clk);
        do_rd(2'd0, d); chk("R6 A pins", {16'h0, d}, 24'h77);
        do_rd(2'd1, d); chk("R6 B pins", {16'h0, d}, 24'h3C);
        // pin change in the same cycle as the read strobe
        @(negedge clk); pad_in[15:8] = 8'h81; cs = 1; rd = 1; addr = 2'd1;
        @(negedge clk); d = rdata; cs = 0; rd = 0;
        chk("R6 old level", {16'h0, d}, 24'h3C);
        @(negedge clk);
        do_rd(2'd1, d); chk("R6 new level", {16'h0, d}, 24'h81);
    endtask

    task automatic t_portc_mixed;
        logic [7:0] d;
        pad_in[23:16] = 8'hE3;
        do_wr(2'd3, 8'h88);
        do_wr(2'd2, 8'h5A);
        do_rd(2'd2, d); chk("R7 hi pins lo latch", {16'h0, d}, 24'hEA);
        do_wr(2'd3, 8'h81);
        do_wr(2'd2, 8'h5A);
        do_rd(2'd2, d); chk("R7 hi latch lo pins", {16'h0, d}, 24'h53);
    endtask

    task automatic t_write_input;
        logic [7:0] d;
        pad_in[7:0] = 8'h21;
        do_wr(2'd3, 8'h90);
        do_wr(2'd0, 8'h66);
        chk("R8 oe low", {16'h0, pad_oe[7:0]}, 24'h0);
        chk("R8 latch", {16'h0, pad_out[7:0]}, 24'h66);
        do_rd(2'd0, d); chk("R8 reads pins", {16'h0, d}, 24'h21);
    endtask

    task automatic t_addr3;
        logic [7:0] d;
        do_rd(2'd3, d); chk("R9 ctrl read", {16'h0, d}, 24'h0);
    endtask

    task automatic t_rd_wr_same;
        logic [7:0] d;
        do_wr(2'd3, 8'h80);
        do_wr(2'd1, 8'h12);
        @(negedge clk); cs = 1; rd = 1; wr = 1; addr = 2'd1; wdata = 8'h34;
        @(negedge clk); d = rdata; cs = 0; rd = 0; wr = 0;
        chk("R10 pre-write", {16'h0, d}, 24'h12);
        do_rd(2'd1, d); chk("R10 post-write", {16'h0, d}, 24'h34);
    endtask

    task automatic t_cs_low;
        @(negedge clk); cs = 0; wr = 1; addr = 2'd0; wdata = 8'hAB;
        @(negedge clk); wr = 0;
        chk("R11 no write", {16'h0, pad_out[7:0]}, 24'h0);
        @(negedge clk); cs = 0; wr = 1; addr = 2'd3; wdata = 8'h9B;
        @(negedge clk); wr = 0;
        chk("R11 no ctrl", pad_oe, 24'hFFFFFF);
        @(negedge clk); rd = 1; addr = 2'd1;
        @(negedge clk); rd = 0;
        chk("R11 no read", {16'h0, rdata}, 24'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_outputs_rw();
        t_dir_bits();
        t_ignored_ctrl();
        t_modeset_clear();
        t_input_sync();
        t_portc_mixed();
        t_write_input();
        t_addr3();
        t_rd_wr_same();
        t_cs_low();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule